// File: doc/BRIEF.md
# Vertical-Crosswise Hierarchical Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is built by recursion. At the bottom is a 2×2 cell that forms its four product bits from vertical and crosswise bit products. Each wider level cuts both operands into a low and a high half. Four half-width multipliers form the lo×lo, lo×hi, hi×lo and hi×hi products. A fixed set of three ripple-carry adders then merges those four results. The default width is 8, which gives two levels of merging above the cells.

The multiplier core has no clock. A parameter selects whether the product goes straight to the output or through an output register. That register is cleared by an asynchronous active-low reset. N must be a power of two and at least 2.

Top module: `vcm_mult`

## Requirements
- R1: In the 2×2 cell, product bit 0 is the AND of operand bit 0 of `a` and operand bit 0 of `b`.
- R2: In the 2×2 cell, product bit 1 is the sum bit of a1·b0 + a0·b1.
- R3: In the 2×2 cell, product bit 2 is the sum bit of a1·b1 plus the carry out of the bit-1 addition. Product bit 3 is the carry out of that bit-2 addition. Together the four bits equal a·b for all 16 operand pairs.
- R4: For a width W above 2, both operands are split into equal halves of W/2 bits. The four half-width products lo×lo, lo×hi, hi×lo and hi×hi are formed by instances of the same multiplier one level down.
- R5: At each level above 2, exactly three ripple-carry adders merge the four half-width products:
  - The low W/2 bits of lo×lo go straight to the low product bits.
  - The first adder sums the two cross products.
  - The second adder adds the upper half of lo×lo to that sum, and its carry out is always 0.
  - The third adder adds hi×hi, shifted up by W/2, to the result of the second adder.
- R6: The third adder never produces a carry out, including for the all-ones operands. For N=8, 255×255 gives 65025.
- R7: For every pair of unsigned N-bit operands, the 2N-bit result equals a·b.
- R8: With REG_OUT=1, `p` shows the product of the operands sampled at the previous rising clock edge. It holds that value until the next edge. While `rst_n` is low, `p` is 0.
- R9: With REG_OUT=0, `p` follows the operands with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| p | output | 2N | Unsigned product |

## Verification
Some checks run on every evaluation, at every level of the recursion:
- The 2×2 cell's four bits form a·b.
- The middle merge adder and the top merge adder never carry out.
- Each stage's result equals the product of its own inputs.
- With the register present, a clocked check compares `p` against the previous cycle's operands.

Other behaviour only the bench scenarios show:
- The individual cell bits, seen through a 2-bit instance.
- The full 4-bit and 8-bit operand spaces.
- The cleared output during reset.
- That the registered output does not move until the clock edge, while the unregistered variant responds at once.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // single-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // single-bit full adder, carry output
  function automatic logic fa_cry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  // half adder sum and carry
  function automatic logic ha_sum(input logic x, input logic y);
    return x ^ y;
  endfunction

  function automatic logic ha_cry(input logic x, input logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2
  import vcm_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);

  // vertical and crosswise bit products
  logic vert_lo, vert_hi, cross_x, cross_y;
  // crosswise sum and its carry, top column sum and its carry
  logic col1_sum, col1_cry, col2_sum, col2_cry;

  assign vert_lo  = a[0] & b[0];
  assign vert_hi  = a[1] & b[1];
  assign cross_x  = a[1] & b[0];
  assign cross_y  = a[0] & b[1];

  assign col1_sum = ha_sum(cross_x, cross_y);
  assign col1_cry = ha_cry(cross_x, cross_y);
  assign col2_sum = ha_sum(vert_hi, col1_cry);
  assign col2_cry = ha_cry(vert_hi, col1_cry);

  assign p = {col2_cry, col2_sum, col1_sum, vert_lo};

  // R3: the four cell bits taken together form the arithmetic product
  always_comb begin
    p_cell_value_r3: assert (p == 4'(a) * 4'(b))
      else $error("cell2 product mismatch");
  end

endmodule

// File: rtl/vcm_rca.sv
module vcm_rca
  import vcm_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_cry(x[i], y[i], chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/vcm_stage.sv
module vcm_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  if (W == 2) begin : g_leaf
    vcm_cell2 u_cell (
      .a (a),
      .b (b),
      .p (p)
    );
  end else begin : g_split
    localparam int H   = W / 2;
    localparam int MW  = W + 1;   // width of the middle sum
    localparam int TW  = 3 * H;   // width of the top merge

    logic [H-1:0] a_lo, a_hi, b_lo, b_hi;
    assign a_lo = a[H-1:0];
    assign a_hi = a[W-1:H];
    assign b_lo = b[H-1:0];
    assign b_hi = b[W-1:H];

    // the four half-width products (R4)
    logic [W-1:0] prod_ll, prod_lh, prod_hl, prod_hh;

    vcm_stage #(.W(H)) u_ll (.a(a_lo), .b(b_lo), .p(prod_ll));
    vcm_stage #(.W(H)) u_lh (.a(a_lo), .b(b_hi), .p(prod_lh));
    vcm_stage #(.W(H)) u_hl (.a(a_hi), .b(b_lo), .p(prod_hl));
    vcm_stage #(.W(H)) u_hh (.a(a_hi), .b(b_hi), .p(prod_hh));

    // adder 1: cross products
    logic [W-1:0] cross_sum;
    logic         cross_co;
    vcm_rca #(.W(W)) u_add_cross (
      .x    (prod_lh),
      .y    (prod_hl),
      .cin  (1'b0),
      .sum  (cross_sum),
      .cout (cross_co)
    );

    // adder 2: cross sum plus upper half of lo x lo
    logic [MW-1:0] mid_a, mid_b, mid_sum;
    logic          mid_co;
    assign mid_a = {cross_co, cross_sum};
    assign mid_b = {{(H+1){1'b0}}, prod_ll[W-1:H]};
    vcm_rca #(.W(MW)) u_add_mid (
      .x    (mid_a),
      .y    (mid_b),
      .cin  (1'b0),
      .sum  (mid_sum),
      .cout (mid_co)
    );

    // adder 3: middle sum plus hi x hi shifted by a half width
    logic [TW-1:0] top_a, top_b, top_sum;
    logic          top_co;
    assign top_a = {{(H-1){1'b0}}, mid_sum};
    assign top_b = {prod_hh, {H{1'b0}}};
    vcm_rca #(.W(TW)) u_add_top (
      .x    (top_a),
      .y    (top_b),
      .cin  (1'b0),
      .sum  (top_sum),
      .cout (top_co)
    );

    assign p = {top_sum, prod_ll[H-1:0]};

    always_comb begin
      // R5: the middle merge never spills past its width
      p_mid_fits_r5: assert (mid_co == 1'b0)
        else $error("middle merge carry out at width %0d", W);
      // R6: the final merge never carries out
      p_no_overflow_r6: assert (top_co == 1'b0)
        else $error("top merge carry out at width %0d", W);
      // R7: stage result matches its own operands
      p_stage_product_r7: assert (p == (2*W)'(a) * (2*W)'(b))
        else $error("stage product mismatch at width %0d", W);
    end
  end

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);

  localparam int PW = 2 * N;

  logic [PW-1:0] core_p;

  vcm_stage #(.W(N)) u_core (
    .a (a),
    .b (b),
    .p (core_p)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= core_p;
    end
    assign p = p_q;

    // R8: registered output is the product of last cycle's operands
    p_reg_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (p == PW'($past(a)) * PW'($past(b))))
      else $error("registered product mismatch");
  end else begin : g_comb
    assign p = core_p;

    // R9: unregistered output tracks the operands directly
    always_comb begin
      p_comb_follow_r9: assert (p == PW'(a) * PW'(b))
        else $error("combinational product mismatch");
    end
  end

endmodule

// File: tb/vcm_mult_tb.sv
`timescale 1ns/100ps
module vcm_mult_tb;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [7:0]  a, b;
  logic [15:0] p;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  vcm_mult #(.N(8), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));
  vcm_mult #(.N(2), .REG_OUT(1'b0)) u_cell_dut (
    .clk(clk), .rst_n(rst_n), .a(a2), .b(b2), .p(p2));
  vcm_mult #(.N(4), .REG_OUT(1'b0)) u_four_dut (
    .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .p(p4));

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a = 8'hA5; b = 8'h3C;
    a2 = '0; b2 = '0; a4 = '0; b4 = '0;
    repeat (3) @(negedge clk);
    check("R8 reset clears output", int'(p), 0);

    // 2-bit instance: each cell bit from its own rule
    for (int i = 0; i < 16; i++) begin
      int x, y, c1;
      x = i / 4; y = i % 4;
      a2 = x[1:0]; b2 = y[1:0];
      #0.5;
      c1 = ((x / 2) % 2) * (y % 2) + (x % 2) * ((y / 2) % 2);
      check("R1 cell bit0", int'(p2[0]), (x % 2) * (y % 2));
      check("R2 cell bit1", int'(p2[1]), c1 % 2);
      check("R3 cell bit2", int'(p2[2]), (((x / 2) % 2) * ((y / 2) % 2) + c1 / 2) % 2);
      check("R3 cell bit3", int'(p2[3]), (((x / 2) % 2) * ((y / 2) % 2) + c1 / 2) / 2);
      check("R3 cell value", int'(p2), x * y);
    end

    // 4-bit instance: one level of halving and merging, all pairs
    for (int i = 0; i < 256; i++) begin
      int x, y;
      x = i / 16; y = i % 16;
      a4 = x[3:0]; b4 = y[3:0];
      #0.5;
      check("R4 R5 four-bit product", int'(p4), x * y);
      check("R5 low bits pass through", int'(p4[1:0]), ((x % 4) * (y % 4)) % 4);
    end
    a4 = 4'd13; b4 = 4'd11;
    #0.5;
    check("R9 unregistered follows at once", int'(p4), 143);

    // registered 8-bit instance, exhaustive with a queued reference
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      int x, y;
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check((int'(a) == 255 && int'(b) == 255) ? "R6 all ones" : "R7 R8 product",
              int'(p), e);
        x = i / 256; y = i % 256;
        a = x[7:0]; b = y[7:0];
        #0.5;
        check("R8 holds until edge", int'(p), e);
      end else begin
        x = i / 256; y = i % 256;
        a = x[7:0]; b = y[7:0];
      end
      exp_q.push_back(x * y);
      @(negedge clk);
    end
    check("R6 last product", int'(p), exp_q.pop_front());

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule